// File: doc/BRIEF.md
# Lock-in Chopper Switch Sequencer

This block times the analog front end of a switched boxcar lock-in. It drives four switch enables, grouped as two pairs. Each pair steers one amplifier input either to the signal or to ground, and the two pairs always work in antiphase. One chop period is ten equal states. The first state is a break with every switch off. Four positive-conduction states follow, then a second break, then four negative-conduction states. Each state lasts `PRESCALE` clocks, so the chop frequency is the clock divided by ten times `PRESCALE`.

A measurement window starts the clock after `en` is seen high while the block is idle. The block samples the period count at that moment and clamps it to at least two. It then runs that many chop periods and adds one more full period with every switch off, so the track/hold can settle. Next it raises a one-clock conversion-start strobe, then a one-clock integrator-clear strobe. It spends `RST_HOLD` further clocks with everything quiet and then goes idle. If `en` is still high, the next window begins one clock later.

When `en` falls, the block finishes the state it is in, turns all switches off and goes idle without starting a conversion.

Top module: `chop_seq`

## Requirements
- R1: While reset is asserted, and after it is released with `en` low, `sw_o`, `adc_start` and `integ_rst` are all 0.
- R2: Switch encoding: `sw_o[0]`/`sw_o[1]` are pair A to signal/ground, and `sw_o[2]`/`sw_o[3]` are pair B to signal/ground. The two bits of one pair are never 1 together.
- R3: Inside a window, chop state k (k = 0..9) occupies clocks k·PRESCALE to (k+1)·PRESCALE−1 of each period. States 0 and 5 drive `sw_o` = 0000, states 1–4 drive 1001 (positive) and states 6–9 drive 0110 (negative).
- R4: `sw_o` never changes from one nonzero value to a different nonzero value; every change between conduction phases passes through 0000.
- R5: After N chop periods, one further period of 10·PRESCALE clocks follows with `sw_o` = 0000.
- R6: `adc_start` is high for exactly one clock, the clock right after the settling period, and only when the window completes.
- R7: `integ_rst` is high for exactly one clock, the clock after `adc_start`. RST_HOLD idle clocks and one idle clock follow it before a new window can begin.
- R8: A period-count input of 0 or 1 behaves as 2.
- R9: The period count is sampled only when a window starts; changing it during a window has no effect on that window.
- R10: If `en` is low at the last clock of a chop or settle state, the block returns to idle with switches off and does not raise `adc_start` or `integ_rst`.
- R11: A window begins (state 0 of the first period) on the clock after `en` is sampled high in idle, and windows repeat back to back while `en` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run request |
| n_periods | input | CNT_W | Chop periods per window (values below 2 treated as 2) |
| sw_o | output | 4 | Switch enables: [0] A-signal, [1] A-ground, [2] B-signal, [3] B-ground |
| adc_start | output | 1 | One-clock conversion start strobe |
| integ_rst | output | 1 | One-clock integrator clear strobe |

## Verification
The bench builds the block with PRESCALE = 2 and RST_HOLD = 3. A full window then lasts 20·(N+1)+6 clocks, so the largest count, 255, fits many times into the run next to many short windows. A state length above one clock means that dropping `en` partway through a state, and not only at its end, shows whether the block really completes the state. A small hold value still lets the idle gap between back-to-back windows be checked clock by clock against the reference model.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [2:0] {
    WIN_IDLE   = 3'd0,
    WIN_RUN    = 3'd1,
    WIN_SETTLE = 3'd2,
    WIN_FIRE   = 3'd3,
    WIN_CLR    = 3'd4,
    WIN_GAP    = 3'd5
  } win_e;

  localparam int unsigned PHASE_CNT = 10;
  localparam int unsigned PHASE_W   = 4;
  localparam int unsigned MID_BREAK = 5;

  localparam logic [3:0] SW_OFF = 4'b0000;
  localparam logic [3:0] SW_POS = 4'b1001;  // A to signal, B to ground
  localparam logic [3:0] SW_NEG = 4'b0110;  // A to ground, B to signal

  function automatic logic [3:0] phase_sw(input logic [PHASE_W-1:0] idx);
    if (idx == '0 || idx == PHASE_W'(MID_BREAK)) return SW_OFF;
    else if (idx < PHASE_W'(MID_BREAK))          return SW_POS;
    else                                         return SW_NEG;
  endfunction

endpackage

// File: rtl/chop_tick.sv
module chop_tick #(
  parameter int unsigned PRESCALE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int unsigned TW = (PRESCALE < 2) ? 1 : $clog2(PRESCALE);

  logic [TW-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == TW'(PRESCALE - 1));

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/chop_phase.sv
module chop_phase
  import chop_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               step,
  output logic [PHASE_W-1:0] idx,
  output logic               wrap
);
  logic [PHASE_W-1:0] idx_q, idx_d;

  assign idx  = idx_q;
  assign wrap = step && (idx_q == PHASE_W'(PHASE_CNT - 1));

  always_comb begin
    if (!run)      idx_d = '0;
    else if (wrap) idx_d = '0;
    else if (step) idx_d = idx_q + 1'b1;
    else           idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/chop_count.sv
module chop_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q, cnt_d;

  assign hit = inc && (cnt_q == limit - 1'b1);

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/chop_seq.sv
module chop_seq
  import chop_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PRESCALE = 8,
  parameter int unsigned RST_HOLD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] n_periods,
  output logic [3:0]       sw_o,
  output logic             adc_start,
  output logic             integ_rst
);
  localparam int unsigned     GAP_W = $clog2(RST_HOLD + 1);
  localparam logic [CNT_W-1:0] N_MIN = CNT_W'(2);

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  win_e             state_q, state_d;
  logic [CNT_W-1:0] n_lat_q, n_lat_d;
  logic             n_load;

  logic               chop_run;
  logic               tick_last;
  logic [PHASE_W-1:0] ph_idx;
  logic               ph_wrap;
  logic               per_hit;
  logic               gap_hit;

  assign chop_run = (state_q == WIN_RUN) || (state_q == WIN_SETTLE);

  chop_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk  (clk),
    .rst_n(rst_i_n),
    .run  (chop_run),
    .last (tick_last)
  );

  chop_phase u_phase (
    .clk  (clk),
    .rst_n(rst_i_n),
    .run  (chop_run),
    .step (tick_last),
    .idx  (ph_idx),
    .wrap (ph_wrap)
  );

  chop_count #(.W(CNT_W)) u_periods (
    .clk  (clk),
    .rst_n(rst_i_n),
    .clr  (state_q != WIN_RUN),
    .inc  (ph_wrap),
    .limit(n_lat_q),
    .hit  (per_hit)
  );

  chop_count #(.W(GAP_W)) u_gap (
    .clk  (clk),
    .rst_n(rst_i_n),
    .clr  (state_q != WIN_GAP),
    .inc  (state_q == WIN_GAP),
    .limit(GAP_W'(RST_HOLD)),
    .hit  (gap_hit)
  );

  // window control, next state
  always_comb begin
    state_d = state_q;
    n_load  = 1'b0;
    unique case (state_q)
      WIN_IDLE: begin
        if (en) begin
          state_d = WIN_RUN;
          n_load  = 1'b1;
        end
      end
      WIN_RUN: begin
        if (tick_last && !en) state_d = WIN_IDLE;
        else if (per_hit)     state_d = WIN_SETTLE;
      end
      WIN_SETTLE: begin
        if (tick_last && !en) state_d = WIN_IDLE;
        else if (ph_wrap)     state_d = WIN_FIRE;
      end
      WIN_FIRE: state_d = WIN_CLR;
      WIN_CLR:  state_d = WIN_GAP;
      WIN_GAP: begin
        if (gap_hit) state_d = WIN_IDLE;
      end
      default: state_d = WIN_IDLE;
    endcase
  end

  always_comb begin
    n_lat_d = n_lat_q;
    if (n_load) n_lat_d = (n_periods < N_MIN) ? N_MIN : n_periods;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= WIN_IDLE;
      n_lat_q <= N_MIN;
    end else begin
      state_q <= state_d;
      if (n_load) n_lat_q <= n_lat_d;
    end
  end

  assign sw_o      = (state_q == WIN_RUN) ? phase_sw(ph_idx) : SW_OFF;
  assign adc_start = (state_q == WIN_FIRE);
  assign integ_rst = (state_q == WIN_CLR);

endmodule

// File: rtl/chop_seq_chk.sv
module chop_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] sw_o,
  input logic       adc_start,
  input logic       integ_rst
);
  a_r2_pair_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_o[0] && sw_o[1]) && !(sw_o[2] && sw_o[3]));

  a_r4_break_before_make: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_o != 4'b0000) |=> (sw_o == 4'b0000 || $stable(sw_o)));

  a_r5_off_before_adc: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ($past(sw_o) == 4'b0000 && sw_o == 4'b0000));

  a_r6_adc_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  a_r7_clr_follows_adc: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> (integ_rst && sw_o == 4'b0000));

  a_r7_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    integ_rst |=> (!integ_rst && !adc_start));
endmodule

bind chop_seq chop_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sw_o     (sw_o),
  .adc_start(adc_start),
  .integ_rst(integ_rst)
);

// File: tb/chop_seq_bench.sv
module chop_seq_bench;
  localparam int PS   = 2;
  localparam int HOLD = 3;
  localparam int W    = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en_r;
  logic [W-1:0] n_r;
  logic [3:0]   sw_o;
  logic         adc_start;
  logic         integ_rst;

  always #5 clk = ~clk;

  chop_seq #(.CNT_W(W), .PRESCALE(PS), .RST_HOLD(HOLD)) u_chop_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_r),
    .n_periods(n_r),
    .sw_o     (sw_o),
    .adc_start(adc_start),
    .integ_rst(integ_rst)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    m_act    = 0;
  int    m_c      = 0;
  int    m_n      = 2;
  int    adc_cnt  = 0;
  logic [3:0] prev_sw = 4'b0000;
  string phase_tag = "-";
  bit    done = 0;

  function automatic int clampn(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  function automatic int win_len(input int n);
    return (n + 1) * 10 * PS + 3 + HOLD;
  endfunction

  function automatic logic [3:0] exp_sw(input int c, input int n);
    int k;
    if (c >= n * 10 * PS) return 4'b0000;
    k = (c / PS) % 10;
    if (k == 0 || k == 5) return 4'b0000;
    if (k < 5)            return 4'b1001;
    return 4'b0110;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, phase_tag, act, exp, $time);
    end
  endtask

  task automatic model_adv();
    if (m_act) begin
      if (m_c < (m_n + 1) * 10 * PS && (m_c % PS) == PS - 1 && !en_r) m_act = 0;
      else if (m_c == win_len(m_n) - 1) begin
        if (en_r) begin m_c = 0; m_n = clampn(int'(n_r)); end
        else m_act = 0;
      end else m_c++;
    end else if (en_r) begin
      m_act = 1; m_c = 0; m_n = clampn(int'(n_r));
    end
  endtask

  task automatic check_all();
    logic [3:0] es;
    bit ea, er;
    string tsw;
    es  = m_act ? exp_sw(m_c, m_n) : 4'b0000;
    ea  = m_act && (m_c == (m_n + 1) * 10 * PS);
    er  = m_act && (m_c == (m_n + 1) * 10 * PS + 1);
    tsw = !m_act ? "R10" : (m_c < m_n * 10 * PS) ? "R3" : "R5";
    chk(sw_o == es, tsw, int'(sw_o), int'(es));
    chk(adc_start == ea, "R6", int'(adc_start), int'(ea));
    chk(integ_rst == er, "R7", int'(integ_rst), int'(er));
    chk(!(sw_o[0] && sw_o[1]) && !(sw_o[2] && sw_o[3]), "R2", int'(sw_o), 0);
    chk(!(prev_sw != 0 && sw_o != 0 && sw_o != prev_sw), "R4", int'(sw_o), int'(prev_sw));
    prev_sw = sw_o;
    if (adc_start) adc_cnt++;
  endtask

  task automatic cyc();
    model_adv();
    @(negedge clk);
    check_all();
  endtask

  task automatic drain();
    en_r = 1'b0;
    for (int i = 0; i < 7000 && m_act; i++) cyc();
    cyc();
  endtask

  function automatic logic [W-1:0] pick_n();
    case ($urandom % 6)
      0: return W'(0);
      1: return W'(1);
      2: return W'(2);
      3: return ($urandom % 8 == 0) ? W'(255) : W'(3);
      default: return W'(2 + $urandom % 6);
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; en_r = 1'b0; n_r = W'(2);
    // R1: reset state
    phase_tag = "R1";
    repeat (3) @(negedge clk);
    chk(sw_o == 4'b0000, "R1", int'(sw_o), 0);
    chk(adc_start == 1'b0, "R1", int'(adc_start), 0);
    chk(integ_rst == 1'b0, "R1", int'(integ_rst), 0);
    rst_n = 1'b1;
    repeat (5) cyc();

    // R11: window start and back-to-back windows
    phase_tag = "R11";
    n_r = W'(2); en_r = 1'b1;
    adc_cnt = 0;
    cyc();
    chk(sw_o == 4'b0000, "R11", int'(sw_o), 0);
    repeat (PS) cyc();
    chk(sw_o == 4'b1001, "R11", int'(sw_o), 9);
    repeat (100) cyc();
    chk(adc_cnt == 1, "R6", adc_cnt, 1);

    // R9: count changes inside windows
    phase_tag = "R9";
    for (int i = 0; i < 400; i++) begin
      if (i % 41 == 0) n_r = (i % 82 == 0) ? W'(9) : W'(3);
      cyc();
    end
    drain();

    // R8: counts 0 and 1 behave as 2
    phase_tag = "R8";
    for (int v = 0; v < 2; v++) begin
      n_r = W'(v); en_r = 1'b1; adc_cnt = 0;
      repeat (3 * 10 * PS + 1) cyc();
      en_r = 1'b0;
      repeat (10) cyc();
      chk(adc_cnt == 1, "R8", adc_cnt, 1);
      drain();
    end

    // R10: drop enable inside a chop state and inside settling
    phase_tag = "R10";
    n_r = W'(5); en_r = 1'b1; adc_cnt = 0;
    repeat (37) cyc();
    en_r = 1'b0;
    repeat (300) cyc();
    chk(adc_cnt == 0, "R10", adc_cnt, 0);
    chk(sw_o == 4'b0000, "R10", int'(sw_o), 0);
    n_r = W'(2); en_r = 1'b1;
    repeat (45) cyc();
    en_r = 1'b0;
    repeat (100) cyc();
    chk(adc_cnt == 0, "R10", adc_cnt, 0);

    // constrained random
    phase_tag = "rand";
    for (int i = 0; i < 60000; i++) begin
      int r;
      r = int'($urandom % 1000);
      if (en_r && r < 3) en_r = 1'b0;
      else if (!en_r && r < 80) en_r = 1'b1;
      if ($urandom % 64 == 0) n_r = pick_n();
      cyc();
    end
    drain();
    finish_run();
  end
endmodule